// File: doc/BRIEF.md
# Switch Management SPI Register Port

This block is the management-bus target of a small Ethernet switch. A host reaches the switch's byte-wide configuration space over a four-wire SPI link in mode 0. Every transaction opens with a command byte that selects write or read, continues with a register address byte, and then carries any number of data bytes. Writes store into the register space; reads shift register contents back on MISO. Within a burst the register address advances after every data byte.

Two identification registers sit at the bottom of the space. Register 0x00 is a fixed family code. Register 0x01 packs a chip code and a revision into its upper bits, and its bit 0 is the switch run control. That bit drives the `sw_start` output to the rest of the switch. All SPI pins are brought into the system clock domain through synchronizers, so the system clock must run at least eight times the SCLK rate.

Top module: `spi_reg_port`

## Requirements
- R1: Mode 0 framing: MOSI is sampled on SCLK rising edges while CS_N is low, 8 bits per byte, most significant bit first.
- R2: The first byte of a transaction is the command (0x02 = write, 0x03 = read) and the second byte is the register address.
- R3: Any other command byte causes every later byte to be ignored until CS_N goes high, and MISO stays 0 for the rest of that transaction.
- R4: Register 0x00 always reads 0x95, and writes to it have no effect.
- R5: Register 0x01 reads as {chip code in bits 7:4 (default 0), revision in bits 3:1 (default 1), run bit in bit 0}, and writes change only bit 0.
- R6: `sw_start` equals the run bit: writing 0 to bit 0 of register 0x01 clears it and writing 1 sets it.
- R7: The address advances by one after each data byte and wraps from 0x7F to 0x00; bit 7 of the address byte is ignored.
- R8: Read data goes out MSB first on MISO. The first bit is valid from the SCLK falling edge that ends the address byte, and later bits change on falling edges. MISO is 0 during the header and while CS_N is high.
- R9: CS_N going high discards a partial byte: no register changes from it, and the next transaction starts cleanly with a command byte.
- R10: Registers 0x02 to 0x7F are read/write storage that resets to 0x00.
- R11: After reset, MISO is 0 and `sw_start` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCLK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idles low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| sw_start | output | 1 | Switch run control (register 0x01 bit 0) |

## Verification
The hardest case to reach from the pins is a chip-select rise in the middle of a byte. The outcome has to be proven by what does not happen: no write to the current register or the one after it, and a clean restart of header decoding. The bench drives CS_N high after a few bits of a data byte, and also after a few bits of an address byte. It then reads both affected addresses back in a fresh burst. Wrap-around is reached with bursts that start at 0x7E and 0x7F, so one burst crosses both the top of the space and the read-only identification registers.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam logic [7:0] OPC_WRITE = 8'h02;
  localparam logic [7:0] OPC_READ  = 8'h03;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_CMD,
    FR_ADDR,
    FR_WRITE,
    FR_READ,
    FR_SKIP
  } frame_st_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic cs_n_in,
  input  logic mosi_in,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic mosi_s
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sclk_q, cs_q, mosi_q;
  logic         sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[TOP-1:0], sclk_in};
      cs_q   <= {cs_q[TOP-1:0], cs_n_in};
      mosi_q <= {mosi_q[TOP-1:0], mosi_in};
      sclk_d <= sclk_q[TOP];
    end
  end

  assign sclk_rise = sclk_q[TOP] & ~sclk_d;
  assign sclk_fall = ~sclk_q[TOP] & sclk_d;
  assign cs_act    = ~cs_q[TOP];
  assign mosi_s    = mosi_q[TOP];
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cs_act,
  input  logic              mosi_s,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              wr_en,
  output logic [7:0]        wr_data,
  output logic              miso
);
  frame_st_t         state, state_n;
  logic [2:0]        bit_cnt, bit_cnt_n;
  logic [6:0]        rx, rx_n;
  logic [ADDR_W-1:0] addr, addr_n;
  logic              is_rd, is_rd_n;
  logic              load_req, load_req_n;
  logic [7:0]        tx, tx_n;
  logic              miso_n;
  logic [7:0]        byte_now;
  logic              byte_end;

  assign byte_now = {rx, mosi_s};
  assign byte_end = sclk_rise && (bit_cnt == 3'd7) && (state != FR_IDLE);

  always_comb begin
    state_n    = state;
    bit_cnt_n  = bit_cnt;
    rx_n       = rx;
    addr_n     = addr;
    is_rd_n    = is_rd;
    load_req_n = 1'b0;
    tx_n       = tx;
    miso_n     = miso;
    wr_en      = 1'b0;
    if (!cs_act) begin
      state_n   = FR_IDLE;
      bit_cnt_n = 3'd0;
      tx_n      = 8'h00;
      miso_n    = 1'b0;
    end else begin
      if (state == FR_IDLE) state_n = FR_CMD;
      if (sclk_rise && state != FR_IDLE) begin
        rx_n      = byte_now[6:0];
        bit_cnt_n = bit_cnt + 3'd1;
      end
      if (load_req) begin
        tx_n   = rd_data;
        addr_n = addr + 1'b1;
      end
      if (byte_end) begin
        unique case (state)
          FR_CMD: begin
            is_rd_n = (byte_now == OPC_READ);
            if (byte_now == OPC_WRITE || byte_now == OPC_READ) state_n = FR_ADDR;
            else state_n = FR_SKIP;
          end
          FR_ADDR: begin
            addr_n     = byte_now[ADDR_W-1:0];
            state_n    = is_rd ? FR_READ : FR_WRITE;
            load_req_n = is_rd;
          end
          FR_WRITE: begin
            wr_en  = 1'b1;
            addr_n = addr + 1'b1;
          end
          FR_READ:  load_req_n = 1'b1;
          default:  ;
        endcase
      end
      if (sclk_fall) begin
        miso_n = tx[7];
        tx_n   = {tx[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= FR_IDLE;
      bit_cnt  <= 3'd0;
      rx       <= 7'd0;
      addr     <= '0;
      is_rd    <= 1'b0;
      load_req <= 1'b0;
      tx       <= 8'h00;
      miso     <= 1'b0;
    end else begin
      state    <= state_n;
      bit_cnt  <= bit_cnt_n;
      rx       <= rx_n;
      addr     <= addr_n;
      is_rd    <= is_rd_n;
      load_req <= load_req_n;
      tx       <= tx_n;
      miso     <= miso_n;
    end
  end

  assign reg_addr = addr;
  assign wr_data  = byte_now;

  assert_skip_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FR_SKIP) |-> !miso);
  assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (addr == ADDR_W'($past(addr) + 1'b1)));
  assert_miso_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !miso);
  assert_abort_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_act) |=> (bit_cnt == 3'd0 && state == FR_IDLE));
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile #(
  parameter int         REGS    = 128,
  parameter int         ADDR_W  = 7,
  parameter logic [7:0] FAMILY  = 8'h95,
  parameter logic [3:0] CHIP_ID = 4'h0,
  parameter logic [2:0] REV     = 3'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              start
);
  logic [7:0] store [REGS-1:2];
  logic       start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      for (int i = 2; i < REGS; i++) store[i] <= 8'h00;
    end else begin
      if (wr_en && addr == ADDR_W'(1)) start_q <= wr_data[0];
      for (int i = 2; i < REGS; i++)
        if (wr_en && addr == ADDR_W'(i)) store[i] <= wr_data;
    end
  end

  always_comb begin
    if (addr == ADDR_W'(0))      rd_data = FAMILY;
    else if (addr == ADDR_W'(1)) rd_data = {CHIP_ID, REV, start_q};
    else                         rd_data = store[addr];
  end

  assign start = start_q;

  assert_start_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(1)) |=> (start == $past(wr_data[0])));
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port #(
  parameter int         REGS        = 128,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] FAMILY      = 8'h95,
  parameter logic [3:0] CHIP_ID     = 4'h0,
  parameter logic [2:0] REV         = 3'd1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic sw_start
);
  localparam int ADDR_W = $clog2(REGS);

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              sclk_rise, sclk_fall, cs_act, mosi_s;
  logic [ADDR_W-1:0] reg_addr;
  logic              wr_en;
  logic [7:0]        wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  spi_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n),
    .sclk_in(spi_sclk), .cs_n_in(spi_cs_n), .mosi_in(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_act(cs_act), .mosi_s(mosi_s)
  );

  spi_frame #(.ADDR_W(ADDR_W)) u_frame (
    .clk(clk), .rst_n(rst_int_n),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_act(cs_act), .mosi_s(mosi_s), .rd_data(rd_data),
    .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
    .miso(spi_miso)
  );

  spi_regfile #(
    .REGS(REGS), .ADDR_W(ADDR_W),
    .FAMILY(FAMILY), .CHIP_ID(CHIP_ID), .REV(REV)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(wr_en), .addr(reg_addr), .wr_data(wr_data),
    .rd_data(rd_data), .start(sw_start)
  );
endmodule

// File: tb/spi_reg_port_test.sv
`timescale 1ns/1ps
module spi_reg_port_test;
  localparam int HALF = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, sw_start;

  int  n_chk = 0, n_fail = 0;
  bit  busy = 1'b1;
  bit  done = 1'b0;
  int  mdl [128];
  bit  mdl_start = 1'b0;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  always #10 clk = ~clk;

  spi_reg_port uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .sw_start(sw_start)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R6: run output compared with the model on every quiet clock
  always @(negedge clk)
    if (rst_n && !busy && !done) check("R6 sw_start", int'(sw_start), int'(mdl_start));

  function automatic int exp_reg(input int a);
    int m = a & 8'h7f;
    if (m == 0) return 8'h95;
    if (m == 1) return {4'h0, 3'd1, mdl_start};
    return mdl[m];
  endfunction

  function automatic void mdl_write(input int a, input int d);
    int m = a & 8'h7f;
    if (m == 1) mdl_start = d[0];
    else if (m >= 2) mdl[m] = d & 8'hff;
  endfunction

  task automatic cs_begin();
    busy = 1'b1;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
    busy = 1'b0;
  endtask

  // shifts nb bits of w MSB first; MISO is sampled just before each rising edge
  task automatic xbyte(input logic [7:0] w, input int nb, output logic [7:0] r);
    r = 8'h00;
    for (int b = 7; b > 7 - nb; b--) begin
      mosi = w[b];
      repeat (HALF) @(negedge clk);
      r[b] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic header(input logic [7:0] cmd, input logic [7:0] adr);
    logic [7:0] r0, r1;
    xbyte(cmd, 8, r0);
    xbyte(adr, 8, r1);
    check("R8 header miso low", int'(r0 | r1), 0);
  endtask

  task automatic wr_burst(input logic [7:0] adr, input int n);
    logic [7:0] r;
    cs_begin();
    header(8'h02, adr);
    for (int i = 0; i < n; i++) begin
      xbyte(wbuf[i], 8, r);
      mdl_write(adr + i, wbuf[i]);
    end
    cs_end();
  endtask

  task automatic rd_burst(input logic [7:0] adr, input int n, input string req);
    cs_begin();
    header(8'h03, adr);
    for (int i = 0; i < n; i++) xbyte(8'h00, 8, rbuf[i]);
    cs_end();
    for (int i = 0; i < n; i++) check(req, int'(rbuf[i]), exp_reg(adr + i));
  endtask

  initial begin
    repeat (1500000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    for (int i = 0; i < 128; i++) mdl[i] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R11 reset miso", int'(miso), 0);
    check("R11 reset sw_start", int'(sw_start), 0);
    busy = 1'b0;

    // R1 R2 R4 R5: identification registers in one burst
    rd_burst(8'h00, 2, "R4 R5 id read");
    // R10: storage resets to zero
    rd_burst(8'h05, 1, "R10 reset value");

    // R7 R10 R1: burst write and read back with varied patterns
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h00; wbuf[3] = 8'hFF;
    wr_burst(8'h10, 4);
    rd_burst(8'h10, 4, "R7 R10 burst readback");

    // R5 R6: only bit 0 of register 0x01 is writable
    wbuf[0] = 8'hFF;
    wr_burst(8'h01, 1);
    check("R6 start set", int'(sw_start), 1);
    rd_burst(8'h01, 1, "R5 id1 with run bit");
    wbuf[0] = 8'hFE;
    wr_burst(8'h01, 1);
    check("R6 start cleared", int'(sw_start), 0);
    rd_burst(8'h01, 1, "R5 upper bits ignore writes");

    // R4: family code is read-only
    wbuf[0] = 8'h12;
    wr_burst(8'h00, 1);
    rd_burst(8'h00, 1, "R4 family read-only");

    // R7: wrap from 0x7F to 0x00 on write and read
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h01;
    wr_burst(8'h7E, 4);
    check("R6 start via wrap", int'(sw_start), 1);
    rd_burst(8'h7E, 5, "R7 wrap burst");

    // R7: bit 7 of the address byte is ignored
    wbuf[0] = 8'h5A;
    wr_burst(8'h85, 1);
    rd_burst(8'h05, 1, "R7 address bit7 ignored");

    // R3: unknown command byte, MISO stays low and nothing is written
    cs_begin();
    xbyte(8'h05, 8, r); check("R3 miso low", int'(r), 0);
    xbyte(8'h10, 8, r); check("R3 miso low", int'(r), 0);
    for (int i = 0; i < 3; i++) begin
      xbyte(8'hEE, 8, r); check("R3 miso low", int'(r), 0);
    end
    cs_end();
    cs_begin();
    xbyte(8'h00, 8, r);
    xbyte(8'h03, 8, r);
    xbyte(8'h10, 8, r); check("R3 miso low cmd 00", int'(r), 0);
    cs_end();
    rd_burst(8'h10, 2, "R3 nothing written");

    // R9: chip select rises inside a data byte
    cs_begin();
    header(8'h02, 8'h20);
    xbyte(8'h77, 8, r); mdl_write(8'h20, 8'h77);
    xbyte(8'h99, 5, r);
    cs_end();
    rd_burst(8'h20, 2, "R9 partial data byte dropped");

    // R9: chip select rises inside the address byte, next frame decodes cleanly
    cs_begin();
    xbyte(8'h02, 8, r);
    xbyte(8'h21, 4, r);
    cs_end();
    rd_burst(8'h20, 2, "R9 partial header dropped");

    // R1 R8: long read crossing id and storage registers
    rd_burst(8'h7F, 6, "R8 long read burst");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule